// File: doc/BRIEF.md
# Selectable Output Coding Formatter

This block sits behind a 16-bit converter core. The core delivers each result as a plain offset-binary word, together with two flags: one for an input above the top of the range and one for an input at or below the bottom of the range. The block turns that word into the output code the system asks for and produces an overflow flag. It also drives the output register with a drive-enable for each bit, which stands in for a three-state pin.

One select line chooses between the true coding and the inverted coding. A second MSB output always carries the inverse of the main MSB. A receiver that reads the second MSB in place of the first therefore sees two's complement or complementary two's complement, and needs no extra logic to do so.

The core's busy signal frames each conversion. A result is taken into the output register when busy falls. Changes to the select line or the output enable are not allowed while busy is high. During that time the block keeps the previous setting and raises an error flag.

Top module: `adc_code_fmt`

## Requirements
- R1: After reset, every output driver is disabled, the coding is the inverted form (select treated as 1), the stored code is zero so the data reads 0xFFFF, and overflow and the error flag are 0.
- R2: With the active select at 0, the data equals the stored offset-binary code (0x8000 for zero input, 0x7FFF for minus half an LSB) and the second MSB is its inverse, giving two's complement.
- R3: With the active select at 1, every data bit is the inverse of the stored code and the second MSB is again the inverse of data bit 15.
- R4: The stored code, and with it overflow, is updated only at the clock edge that samples busy low after it was sampled high. It is visible from that edge, and raw-code changes at any other time have no effect.
- R5: If the above-range flag is set at capture, the stored code becomes all ones and overflow becomes 1. If only the below-range flag is set, the stored code becomes all zeros and overflow becomes 1. The above-range flag wins when both are set. Under the inverted coding the data therefore reads 0x0000 and 0xFFFF respectively.
- R6: When the active output enable is 0, all 16 data drive-enables and the second-MSB drive-enable are 1. When it is 1, they are all 0. Overflow and the error flag are always driven.
- R7: At an edge that samples busy high, the active select and the active enable keep their values. The error flag is 1 in the cycle after any such edge at which the select or enable input differs from its active value, and 0 otherwise.
- R8: At an edge that samples busy low, the select and enable inputs become active. A change held through a conversion takes effect at the edge where busy is first sampled low again, which is the same edge that captures the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_code | input | 16 | Offset-binary result from the converter core |
| ovr_hi | input | 1 | Input above the range that gives all ones |
| ovr_lo | input | 1 | Input at or below the range that gives all zeros |
| comp_sel | input | 1 | Coding select: 1 inverted, 0 true |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Conversion in progress |
| dout | output | 16 | Formatted data bits |
| dout_en | output | 16 | Drive-enable for each data bit |
| msb_inv | output | 1 | Second MSB, inverse of dout[15] |
| msb_inv_en | output | 1 | Drive-enable of the second MSB |
| ovf | output | 1 | Overflow flag |
| ctl_err | output | 1 | Select or enable changed while busy |

## Verification
At the falling edge of busy, two things can happen at the same clock edge: a new result is captured, and a select or enable change that was held back during the conversion is applied. The bench provokes this by toggling the select while busy is high and keeping the new value as busy drops. The cycle after that edge must show the new code already in the new coding, with the error flag cleared. Random stimulus also lands enable changes, out-of-range flags and capture edges on shared edges. A behavioural reference model checks every output in every cycle.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic {
    CODE_TRUE = 1'b0,
    CODE_INV  = 1'b1
  } coding_e;
endpackage

// File: rtl/fmt_ctl_guard.sv
module fmt_ctl_guard
  import fmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy,
  input  logic    comp_sel,
  input  logic    oe_n,
  output coding_e coding,
  output logic    oe_act_n,
  output logic    ctl_err
);
  coding_e coding_q, coding_d;
  logic    oe_q, oe_d, err_q, err_d;
  logic    upd_en;

  // settings may only follow the pins outside a conversion
  assign upd_en = ~busy;

  always_comb begin
    coding_d = coding_q;
    oe_d     = oe_q;
    if (upd_en) begin
      coding_d = comp_sel ? CODE_INV : CODE_TRUE;
      oe_d     = oe_n;
    end
    err_d = busy & ((comp_sel != logic'(coding_q)) | (oe_n != oe_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coding_q <= CODE_INV;
      oe_q     <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      coding_q <= coding_d;
      oe_q     <= oe_d;
      err_q    <= err_d;
    end
  end

  assign coding   = coding_q;
  assign oe_act_n = oe_q;
  assign ctl_err  = err_q;

  p_hold_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(coding_q) && $stable(oe_q));
  p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (comp_sel != logic'(coding_q))) |=> err_q);
  p_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (logic'(coding_q) == $past(comp_sel)) && (oe_q == $past(oe_n)));
endmodule

// File: rtl/fmt_result_capture.sv
module fmt_result_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic [W-1:0] raw_code,
  input  logic         ovr_hi,
  input  logic         ovr_lo,
  output logic [W-1:0] code,
  output logic         ovf
);
  logic         busy_q;
  logic         cap_en;
  logic [W-1:0] code_q, code_d;
  logic         hi_q, hi_d, lo_q, lo_d;

  // capture on the sampled high-to-low step of busy
  assign cap_en = busy_q & ~busy;

  always_comb begin
    code_d = code_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (cap_en) begin
      hi_d = ovr_hi;
      lo_d = ovr_lo & ~ovr_hi;
      if (ovr_hi)      code_d = '1;
      else if (ovr_lo) code_d = '0;
      else             code_d = raw_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      busy_q <= busy;
      code_q <= code_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign code = code_q;
  assign ovf  = hi_q | lo_q;

  p_hold_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && !busy) |=> $stable(code_q) && $stable(ovf));
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> (&code_q));
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q |-> (code_q == '0));
endmodule

// File: rtl/fmt_code_map.sv
module fmt_code_map
  import fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] code,
  input  coding_e      coding,
  input  logic         oe_act_n,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_en,
  output logic         msb_inv,
  output logic         msb_inv_en
);
  localparam int MSB = W - 1;

  assign dout       = (coding == CODE_INV) ? ~code : code;
  assign msb_inv    = ~dout[MSB];
  assign msb_inv_en = ~oe_act_n;

  for (genvar i = 0; i < W; i++) begin : g_drv
    assign dout_en[i] = ~oe_act_n;
  end

  always_comb begin
    a_drv_match_r6: assert (dout_en[0] == msb_inv_en);
  end
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
  import fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_code,
  input  logic         ovr_hi,
  input  logic         ovr_lo,
  input  logic         comp_sel,
  input  logic         oe_n,
  input  logic         busy,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_en,
  output logic         msb_inv,
  output logic         msb_inv_en,
  output logic         ovf,
  output logic         ctl_err
);
  coding_e      coding;
  logic         oe_act_n;
  logic [W-1:0] code;

  fmt_ctl_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .comp_sel (comp_sel),
    .oe_n     (oe_n),
    .coding   (coding),
    .oe_act_n (oe_act_n),
    .ctl_err  (ctl_err)
  );

  fmt_result_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .raw_code (raw_code),
    .ovr_hi   (ovr_hi),
    .ovr_lo   (ovr_lo),
    .code     (code),
    .ovf      (ovf)
  );

  fmt_code_map #(.W(W)) u_map (
    .code       (code),
    .coding     (coding),
    .oe_act_n   (oe_act_n),
    .dout       (dout),
    .dout_en    (dout_en),
    .msb_inv    (msb_inv),
    .msb_inv_en (msb_inv_en)
  );

  p_msb_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msb_inv != dout[W-1]);
  p_quiet_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !ctl_err);
endmodule

// File: tb/adc_code_fmt_bench.sv
`timescale 1ns/1ps
module adc_code_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] raw_code = '0;
  logic        ovr_hi = 1'b0, ovr_lo = 1'b0;
  logic        comp_sel = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [15:0] dout, dout_en;
  logic        msb_inv, msb_inv_en, ovf, ctl_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_code_fmt u_adc_code_fmt (
    .clk(clk), .rst_n(rst_n), .raw_code(raw_code), .ovr_hi(ovr_hi),
    .ovr_lo(ovr_lo), .comp_sel(comp_sel), .oe_n(oe_n), .busy(busy),
    .dout(dout), .dout_en(dout_en), .msb_inv(msb_inv),
    .msb_inv_en(msb_inv_en), .ovf(ovf), .ctl_err(ctl_err)
  );

  // behavioural reference model
  logic [15:0] m_code;
  bit m_ovf, m_comp, m_oe, m_busy_q, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 16'h0000; m_ovf = 0; m_comp = 1; m_oe = 1; m_busy_q = 0; m_err = 0;
    end else begin
      if (m_busy_q && !busy) begin
        m_ovf = ovr_hi || ovr_lo;
        if (ovr_hi)      m_code = 16'hFFFF;
        else if (ovr_lo) m_code = 16'h0000;
        else             m_code = raw_code;
      end
      m_err = busy && ((comp_sel != m_comp) || (oe_n != m_oe));
      if (!busy) begin m_comp = comp_sel; m_oe = oe_n; end
      m_busy_q = busy;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] e_d;
      e_d = m_comp ? ~m_code : m_code;
      chk(m_comp ? "R3 data" : "R2 data", {16'h0, dout}, {16'h0, e_d});
      chk("R2 msb_inv", {31'h0, msb_inv}, {31'h0, ~e_d[15]});
      chk("R6 enables", {15'h0, msb_inv_en, dout_en}, {15'h0, !m_oe, {16{!m_oe}}});
      chk("R5 ovf", {31'h0, ovf}, {31'h0, m_ovf});
      chk("R7 err", {31'h0, ctl_err}, {31'h0, m_err});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic conv(input logic [15:0] v, input bit hi, input bit lo);
    busy = 1; cyc(3);
    raw_code = v; ovr_hi = hi; ovr_lo = lo; busy = 0;
    cyc(1);
  endtask

  initial begin : watchdog
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 data", {16'h0, dout}, 32'h0000FFFF);
    chk("R1 enables", {15'h0, msb_inv_en, dout_en}, 32'h0);
    chk("R1 flags", {30'h0, ovf, ctl_err}, 32'h0);
    rst_n = 1; cyc(2);
    comp_sel = 0; oe_n = 0; cyc(2);
    conv(16'h8000, 0, 0);
    chk("R2 zero code", {15'h0, msb_inv, dout}, {15'h0, 1'b0, 16'h8000});
    conv(16'h7FFF, 0, 0);
    chk("R2 minus half LSB", {15'h0, msb_inv, dout}, {15'h0, 1'b1, 16'h7FFF});
    // R4: raw changes while busy are ignored
    busy = 1; raw_code = 16'h1234; cyc(3);
    chk("R4 hold", {16'h0, dout}, 32'h00007FFF);
    raw_code = 16'h4321; busy = 0; cyc(1);
    chk("R4 capture", {16'h0, dout}, 32'h00004321);
    conv(16'h0005, 1, 1);
    chk("R5 above wins", {15'h0, ovf, dout}, {15'h0, 1'b1, 16'hFFFF});
    comp_sel = 1; cyc(2);
    conv(16'h0005, 0, 1);
    chk("R5 below inverted", {15'h0, ovf, dout}, {15'h0, 1'b1, 16'hFFFF});
    conv(16'h8000, 0, 0);
    chk("R3 inverted zero", {15'h0, msb_inv, dout}, {15'h0, 1'b1, 16'h7FFF});
    // R7 then R8: select toggled during conversion, kept through busy fall
    busy = 1; cyc(1); comp_sel = 0; cyc(1);
    chk("R7 err raised", {31'h0, ctl_err}, 32'h1);
    chk("R7 setting held", {16'h0, dout}, 32'h00007FFF);
    cyc(1);
    raw_code = 16'h00F0; ovr_lo = 0; busy = 0; cyc(1);
    chk("R8 applied with capture", {16'h0, dout}, 32'h000000F0);
    chk("R8 err cleared", {31'h0, ctl_err}, 32'h0);
    // R6 disable
    oe_n = 1; cyc(1);
    chk("R6 disabled", {15'h0, msb_inv_en, dout_en}, 32'h0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      raw_code = 16'($urandom);
      ovr_hi = ($urandom % 8) == 0;
      ovr_lo = ($urandom % 8) == 0;
      busy = ($urandom % 3) != 0;
      if (($urandom % 4) == 0) comp_sel = ~comp_sel;
      if (($urandom % 5) == 0) oe_n = ~oe_n;
      cyc(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule